// File: doc/BRIEF.md
# Binary Shift-Subtract GCD Engine

This block finds the greatest common divisor of two unsigned operands using only shifts, compares and one subtractor. It has no divider and no multiplier. A one-cycle load strobe captures both operands and starts a run. While the run lasts, the engine applies exactly one reduction rule per clock cycle to its working pair. When either working operand becomes zero, the engine restores the factors of two that both operands shared, latches the result and raises a done flag.

The rules work on the low bits of the pair:

- When both values are even, both are halved and a shared two-power counter is incremented.
- When exactly one value is even, only that value is halved.
- When both values are odd, the larger minus the smaller is halved in the same step. The pair becomes (difference/2, smaller).

The surviving nonzero operand is shifted left by the counter through a logarithmic shifter. The operand width is a parameter, and both 4 and 8 bits are supported. A new load strobe always takes priority: it aborts a run in progress, and it also wins over a completion falling in the same cycle.

Top module: `gcd_shift_engine`

## Requirements
- R1: While reset is applied, and after it is released without any load, `done_o` is 0 and `result_o` is 0.
- R2: A zero operand yields the other operand: gcd(x,0)=x and gcd(0,x)=x. The pair (0,0) yields 0.
- R3: For every operand pair, `result_o` equals the greatest common divisor once `done_o` is 1. This covers pairs with one odd operand and pairs with two odd operands, at WIDTH 4 and WIDTH 8.
- R4: Factors of two common to both operands are restored in the result, for example gcd(48,80)=16 and gcd(128,128)=128.
- R5: One rule is applied per cycle. `done_o` rises no later than 2*WIDTH+1 clock edges after the edge that samples the load strobe.
- R6: `done_o` is 0 in the cycle after a load. Once `done_o` is 1, it stays 1 and `result_o` stays unchanged until the next load strobe. Operand inputs are ignored while the load strobe is low.
- R7: A load strobe during a run discards the run and computes the GCD of the new operands.
- R8: A load strobe on the same edge at which a run would complete takes priority. `done_o` stays 0 for the old pair, and the result reported is that of the new pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_i | input | 1 | Load strobe: captures operands and starts a run |
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand |
| result_o | output | WIDTH | GCD of the last completed pair |
| done_o | output | 1 | High from completion until the next load |

## Verification
A completion and a new load strobe can land on the same clock edge. The bench provokes this with a pair containing a zero operand, which is known to finish on the first run edge. It raises the load strobe for a second pair exactly on that edge. It then checks two things: `done_o` stays low after that edge, and the value finally reported is the second pair's GCD, not the first. The same priority is also exercised earlier in a run, by aborting a long odd/odd sequence after two cycles.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } gcd_state_e;
endpackage

// File: rtl/gcd_rst_sync.sv
module gcd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_n = sync_q;
endmodule

// File: rtl/gcd_reduce_step.sv
module gcd_reduce_step #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] u_i,
  input  logic [WIDTH-1:0] v_i,
  output logic [WIDTH-1:0] u_o,
  output logic [WIDTH-1:0] v_o,
  output logic             twos_o,
  output logic             zero_o
);
  logic             u_ge_v;
  logic [WIDTH-1:0] diff;

  always_comb begin
    zero_o = (u_i == '0) || (v_i == '0);
    u_ge_v = (u_i >= v_i);
    diff   = u_ge_v ? (u_i - v_i) : (v_i - u_i);
    twos_o = 1'b0;
    u_o    = u_i;
    v_o    = v_i;
    case ({u_i[0], v_i[0]})
      2'b00: begin
        u_o    = u_i >> 1;
        v_o    = v_i >> 1;
        twos_o = 1'b1;
      end
      2'b01: u_o = u_i >> 1;
      2'b10: v_o = v_i >> 1;
      default: begin
        u_o = diff >> 1;
        v_o = u_ge_v ? v_i : u_i;
      end
    endcase
  end
endmodule

// File: rtl/gcd_twos_count.sv
module gcd_twos_count #(
  parameter int KW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          inc_i,
  output logic [KW-1:0] cnt_o
);
  logic [KW-1:0] cnt_q;
  logic [KW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i | inc_i;
    cnt_d  = clr_i ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/gcd_pow2_restore.sv
module gcd_pow2_restore #(
  parameter int WIDTH = 8,
  parameter int KW    = 4
) (
  input  logic [WIDTH-1:0] val_i,
  input  logic [KW-1:0]    amt_i,
  output logic [WIDTH-1:0] val_o
);
  logic [WIDTH-1:0] stage [KW+1];

  assign stage[0] = val_i;

  for (genvar i = 0; i < KW; i++) begin : g_stage
    assign stage[i+1] = amt_i[i] ? (stage[i] << (2**i)) : stage[i];
  end

  assign val_o = stage[KW];
endmodule

// File: rtl/gcd_shift_engine.sv
module gcd_shift_engine #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  output logic [WIDTH-1:0] result_o,
  output logic             done_o
);
  import gcd_pkg::*;

  localparam int KW = $clog2(WIDTH) + 1;

  logic             rst_sync_n;
  gcd_state_e       state_q, state_d;
  logic [WIDTH-1:0] u_q, u_d, v_q, v_d;
  logic [WIDTH-1:0] res_q, res_d;
  logic             done_q, done_d;
  logic             op_en, res_en;
  logic [WIDTH-1:0] u_nx, v_nx;
  logic             step_twos, step_zero;
  logic [KW-1:0]    twos_cnt;
  logic [WIDTH-1:0] restored;
  logic             cnt_inc;

  gcd_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  gcd_reduce_step #(.WIDTH(WIDTH)) u_step (
    .u_i    (u_q),
    .v_i    (v_q),
    .u_o    (u_nx),
    .v_o    (v_nx),
    .twos_o (step_twos),
    .zero_o (step_zero)
  );

  assign cnt_inc = !load_i && (state_q == ST_RUN) && !step_zero && step_twos;

  gcd_twos_count #(.KW(KW)) u_twos (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (load_i),
    .inc_i (cnt_inc),
    .cnt_o (twos_cnt)
  );

  gcd_pow2_restore #(.WIDTH(WIDTH), .KW(KW)) u_restore (
    .val_i (u_q | v_q),
    .amt_i (twos_cnt),
    .val_o (restored)
  );

  always_comb begin
    state_d = state_q;
    u_d     = u_q;
    v_d     = v_q;
    res_d   = res_q;
    done_d  = done_q;
    op_en   = 1'b0;
    res_en  = 1'b0;
    if (load_i) begin
      op_en   = 1'b1;
      u_d     = opa_i;
      v_d     = opb_i;
      done_d  = 1'b0;
      state_d = ST_RUN;
    end else begin
      case (state_q)
        ST_RUN: begin
          if (step_zero) begin
            res_en  = 1'b1;
            res_d   = restored;
            done_d  = 1'b1;
            state_d = ST_DONE;
          end else begin
            op_en = 1'b1;
            u_d   = u_nx;
            v_d   = v_nx;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      u_q <= '0;
      v_q <= '0;
    end else if (op_en) begin
      u_q <= u_d;
      v_q <= v_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  res_q <= '0;
    else if (res_en)  res_q <= res_d;
  end

  assign result_o = res_q;
  assign done_o   = done_q;
endmodule

// File: rtl/gcd_shift_engine_chk.sv
module gcd_shift_engine_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             load_i,
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic [WIDTH-1:0] result_o,
  input logic             done_o
);
  logic [WIDTH-1:0] cap_a, cap_b;
  logic [15:0]      cnt;
  logic             busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a <= '0;
      cap_b <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
    end else if (load_i) begin
      cap_a <= opa_i;
      cap_b <= opb_i;
      cnt   <= '0;
      busy  <= 1'b1;
    end else if (done_o) begin
      busy  <= 1'b0;
    end else if (busy) begin
      cnt   <= cnt + 16'd1;
    end
  end

  // R6
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> !done_o);

  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !load_i) |=> (done_o && $stable(result_o)));

  // R5
  latency_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= 16'(2*WIDTH+1)));

  // R3
  divides_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && result_o != '0) |-> ((cap_a % result_o) == '0 && (cap_b % result_o) == '0));

  // R2
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && cap_a == '0) |-> (result_o == cap_b));
endmodule

bind gcd_shift_engine gcd_shift_engine_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .load_i   (load_i),
  .opa_i    (opa_i),
  .opb_i    (opb_i),
  .result_o (result_o),
  .done_o   (done_o)
);

// File: tb/test_gcd_shift_engine.sv
module test_gcd_shift_engine;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load8 = 1'b0, load4 = 1'b0;
  logic [7:0] a8 = '0, b8 = '0, r8;
  logic [3:0] a4 = '0, b4 = '0, r4;
  logic       d8, d4;
  int         tests = 0;
  int         fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gcd_shift_engine #(.WIDTH(8)) i_gcd_shift_engine (
    .clk(clk), .rst_n(rst_n), .load_i(load8), .opa_i(a8), .opb_i(b8),
    .result_o(r8), .done_o(d8));

  gcd_shift_engine #(.WIDTH(4)) i_gcd_shift_engine_w4 (
    .clk(clk), .rst_n(rst_n), .load_i(load4), .opa_i(a4), .opb_i(b4),
    .result_o(r4), .done_o(d4));

  function automatic int ref_gcd(int a, int b);
    int x = a;
    int y = b;
    while (y != 0) begin
      int t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic string tag_for(int a, int b);
    if (a == 0 || b == 0) return "R2";
    if (a % 2 == 0 && b % 2 == 0) return "R4";
    return "R3";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_done8(output int cyc);
    cyc = 0;
    while (!d8 && cyc <= 2*8 + 3) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic wait_done4(output int cyc);
    cyc = 0;
    while (!d4 && cyc <= 2*4 + 3) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run8(input int a, input int b);
    int cyc;
    @(negedge clk);
    load8 = 1'b1; a8 = a[7:0]; b8 = b[7:0];
    @(negedge clk);
    load8 = 1'b0;
    chk(d8 == 1'b0, "R6", "w8 done low after load", int'(d8), 0);
    wait_done8(cyc);
    chk(cyc <= 2*8 + 1, "R5", "w8 cycles to done", cyc, 2*8 + 1);
    chk(int'(r8) == ref_gcd(a, b), tag_for(a, b), "w8 gcd", int'(r8), ref_gcd(a, b));
  endtask

  task automatic run4(input int a, input int b);
    int cyc;
    @(negedge clk);
    load4 = 1'b1; a4 = a[3:0]; b4 = b[3:0];
    @(negedge clk);
    load4 = 1'b0;
    chk(d4 == 1'b0, "R6", "w4 done low after load", int'(d4), 0);
    wait_done4(cyc);
    chk(cyc <= 2*4 + 1, "R5", "w4 cycles to done", cyc, 2*4 + 1);
    chk(int'(r4) == ref_gcd(a, b), tag_for(a, b), "w4 gcd", int'(r4), ref_gcd(a, b));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    // R1: reset state, while reset is held and after release
    chk(d8 == 1'b0 && r8 == '0, "R1", "w8 in reset", int'(r8), 0);
    chk(d4 == 1'b0 && r4 == '0, "R1", "w4 in reset", int'(r4), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(d8 == 1'b0 && r8 == '0, "R1", "w8 after release", int'(d8), 0);

    // R2 and R4 corner pairs
    run8(0, 0);   run8(0, 200); run8(173, 0);
    run8(48, 80); run8(128, 128); run8(96, 64);
    run8(255, 1); run8(255, 255); run8(1, 128);

    // R3: exhaustive at WIDTH 4
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run4(a, b);

    // R3: strided sweep at WIDTH 8
    for (int a = 0; a < 256; a += 7)
      for (int b = 0; b < 256; b += 9)
        run8(a, b);

    // R6: result held and operand inputs ignored while load is low
    run8(48, 80);
    a8 = 8'd7; b8 = 8'd3;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(d8 == 1'b1 && r8 == 8'd16, "R6", "w8 held result", int'(r8), 16);
    end

    // R7: abort a long odd/odd run after two cycles
    @(negedge clk);
    load8 = 1'b1; a8 = 8'd255; b8 = 8'd1;
    @(negedge clk);
    load8 = 1'b0;
    @(negedge clk);
    load8 = 1'b1; a8 = 8'd36; b8 = 8'd24;
    @(negedge clk);
    load8 = 1'b0;
    chk(d8 == 1'b0, "R7", "w8 done low after restart", int'(d8), 0);
    wait_done8(cyc);
    chk(r8 == 8'd12, "R7", "w8 restarted gcd", int'(r8), 12);

    @(negedge clk);
    load4 = 1'b1; a4 = 4'd15; b4 = 4'd1;
    @(negedge clk);
    load4 = 1'b0;
    @(negedge clk);
    load4 = 1'b1; a4 = 4'd9; b4 = 4'd6;
    @(negedge clk);
    load4 = 1'b0;
    wait_done4(cyc);
    chk(r4 == 4'd3, "R7", "w4 restarted gcd", int'(r4), 3);

    // R8: load on the edge at which (0,5) would complete
    @(negedge clk);
    load8 = 1'b1; a8 = 8'd0; b8 = 8'd5;
    @(negedge clk);
    a8 = 8'd12; b8 = 8'd18;
    @(negedge clk);
    load8 = 1'b0;
    chk(d8 == 1'b0, "R8", "w8 done suppressed on collision", int'(d8), 0);
    wait_done8(cyc);
    chk(r8 == 8'd6, "R8", "w8 second pair wins", int'(r8), 6);

    // R1: reset again clears a completed result
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(d8 == 1'b0 && r8 == '0, "R1", "w8 cleared by reset", int'(r8), 0);
    chk(d4 == 1'b0 && r4 == '0, "R1", "w4 cleared by reset", int'(r4), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule